// File: doc/BRIEF.md
# Display Refresh FIFO with Urgency Request

This block queues refresh data between a memory controller and the display output side. Memory returns 64-bit words in bursts, one word per clock, and the display side pulls words out one at a time. Every entry carries a one-bit type tag, so pixel words and cursor pattern words share the same queue and leave it in the order they arrived.

The block asks for data in two ways. While its fill level is at or above a programmable watermark, it raises a background request. That request asks for a fill only when a whole burst still fits. Memory can grant it during idle time and keep its open page. When the level drops below the watermark, the block raises an urgent request instead, and the memory arbiter must serve it ahead of every other client. The two requests are never active together. Writing a watermark of zero turns urgent requests off.

Misuse is recorded, not fatal. A read from an empty queue returns the last word again and sets a sticky underflow flag. A write into a full queue is dropped and sets a sticky overflow flag. Writing a one to the matching clear bit clears each flag.

Top module: `disp_refill_fifo`

## Requirements
- R1: While rst_n is low and after its release, level is 0, both sticky flags are 0, rd_word and rd_cursor are 0, and the watermark holds THR_RESET (16). So after reset req_urgent is 1 and req_bg is 0.
- R2: Words leave in arrival order, each with its own tag bit. A write is taken on every clock with wr_en while the queue is not full. On a read taken at a clock edge, rd_word/rd_cursor show the oldest entry after that edge.
- R3: level equals accepted writes minus accepted reads, ranges 0 to 64, and is unchanged by a cycle that both reads and writes.
- R4: req_urgent is 1 exactly when level < watermark. A watermark of 0 keeps it at 0.
- R5: req_bg is 1 exactly when level >= watermark and 64 - level >= BURST (4). It is therefore 0 when full and never 1 together with req_urgent.
- R6: A write while level is 64 is dropped: level stays 64, the contents are unchanged, and overflow becomes 1 and stays 1.
- R7: A read while level is 0 leaves level at 0, keeps rd_word/rd_cursor at the last word read, and sets underflow to 1, where it stays.
- R8: flag_clr bit 0 clears underflow and bit 1 clears overflow. If a setting event happens in the same cycle as the clear, the flag ends up 1.
- R9: thr_we loads thr_wdata into the watermark at the clock edge. The request outputs follow the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Memory data word valid |
| wr_word | input | 64 | Data word from memory |
| wr_cursor | input | 1 | Tag: 1 = cursor pattern, 0 = pixel |
| rd_en | input | 1 | Display side takes one word |
| rd_word | output | 64 | Word last read |
| rd_cursor | output | 1 | Tag of the word last read |
| thr_we | input | 1 | Watermark write strobe |
| thr_wdata | input | 6 | New watermark value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 underflow, bit 1 overflow |
| level | output | 7 | Number of entries held, 0 to 64 |
| req_bg | output | 1 | Background fill request |
| req_urgent | output | 1 | Urgent fill request |
| underflow | output | 1 | Sticky read-while-empty flag |
| overflow | output | 1 | Sticky write-while-full flag |

## Verification
The bench drives the queue to exactly 64 and then writes, and it reads from an empty queue. A wrong full or empty test would move level past its limits, lose a stored word, or change rd_word on the empty read. It walks the level across 60 and 61, where a burst stops fitting. An off-by-one space check would leave req_bg high when a full burst no longer fits. It also sets the watermark to 0 and to 63, and sets a flag in the same cycle that clears it. A design that let the clear win, or compared with <= instead of <, would show the wrong request or flag value within one cycle.

// File: rtl/disp_refill_fifo.sv
module disp_refill_fifo #(
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 64,
  parameter int BURST     = 4,
  parameter int THR_W     = 6,
  parameter int THR_RESET = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              wr_cursor,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_cursor,
  input  logic              thr_we,
  input  logic [THR_W-1:0]  thr_wdata,
  input  logic [1:0]        flag_clr,
  output logic [CW-1:0]     level,
  output logic              req_bg,
  output logic              req_urgent,
  output logic              underflow,
  output logic              overflow
);

  logic [DATA_W:0]    mem [DEPTH];
  logic [AW-1:0]      wp, rp;
  logic [CW-1:0]      cnt;
  logic [THR_W-1:0]   thr_q;
  logic [DATA_W:0]    rd_q;
  logic               unf_q, ovf_q;

  wire full  = (cnt == CW'(DEPTH));
  wire empty = (cnt == '0);
  wire wr_ok = wr_en && !full;
  wire rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= {wr_cursor, wr_word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      rd_q  <= '0;
      thr_q <= THR_W'(THR_RESET);
      unf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_ok) begin
        rp   <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        rd_q <= mem[rp];
      end
      if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
      else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
      if (thr_we) thr_q <= thr_wdata;
      unf_q <= (rd_en && empty) || (unf_q && !flag_clr[0]);
      ovf_q <= (wr_en && full)  || (ovf_q && !flag_clr[1]);
    end
  end

  assign req_urgent = 32'(cnt) < 32'(thr_q);
  assign req_bg     = !req_urgent && (32'(DEPTH) - 32'(cnt) >= 32'(BURST));
  assign level      = cnt;
  assign rd_word    = rd_q[DATA_W-1:0];
  assign rd_cursor  = rd_q[DATA_W];
  assign underflow  = unf_q;
  assign overflow   = ovf_q;

endmodule

module disp_refill_fifo_chk #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  parameter int BURST  = 4,
  parameter int THR_W  = 6,
  parameter int CW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_word,
  input logic [CW-1:0]     level,
  input logic [THR_W-1:0]  thr_q,
  input logic              req_bg,
  input logic              req_urgent,
  input logic              underflow,
  input logic              overflow
);

  assert_req_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_bg && req_urgent));

  assert_no_bg_near_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(level) > 32'(DEPTH - BURST)) |-> !req_bg);

  assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= 32'(DEPTH));

  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == $past(level)) || (level == $past(level) + 1'b1) ||
    (level + 1'b1 == $past(level)));

  assert_zero_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |-> !req_urgent);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && 32'(level) == 32'(DEPTH)) |=> (overflow && 32'(level) == 32'(DEPTH)));

  assert_underflow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |=> (underflow && $stable(rd_word)));

endmodule

bind disp_refill_fifo disp_refill_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .BURST(BURST), .THR_W(THR_W), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_word(rd_word),
  .level(level), .thr_q(thr_q), .req_bg(req_bg), .req_urgent(req_urgent),
  .underflow(underflow), .overflow(overflow)
);

// File: tb/disp_refill_fifo_tb_top.sv
module disp_refill_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_cursor = 1'b0, rd_en = 1'b0, thr_we = 1'b0;
  logic [63:0] wr_word = '0;
  logic [5:0]  thr_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [63:0] rd_word;
  logic        rd_cursor, req_bg, req_urgent, underflow, overflow;
  logic [6:0]  level;

  int checks = 0, errors = 0, cycles = 0;
  logic [64:0] mq[$];
  logic [64:0] exp_rd = '0;
  logic        exp_u = 1'b0, exp_o = 1'b0;
  int          exp_thr = 16;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_refill_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_cursor(wr_cursor),
    .rd_en(rd_en), .rd_word(rd_word), .rd_cursor(rd_cursor), .thr_we(thr_we),
    .thr_wdata(thr_wdata), .flag_clr(flag_clr), .level(level), .req_bg(req_bg),
    .req_urgent(req_urgent), .underflow(underflow), .overflow(overflow));

  function automatic logic exp_urgent(int lv, int th);
    return lv < th;
  endfunction

  function automatic logic exp_bg(int lv, int th);
    return !(lv < th) && (64 - lv >= 4);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    int n = mq.size();
    chk(32'(level) == n, "R3 level", 65'(level), 65'(n));
    chk({rd_cursor, rd_word} == exp_rd, "R2 read word/tag", {rd_cursor, rd_word}, exp_rd);
    chk(req_urgent == exp_urgent(n, exp_thr), "R4 urgent", 65'(req_urgent), 65'(exp_urgent(n, exp_thr)));
    chk(req_bg == exp_bg(n, exp_thr), "R5 background", 65'(req_bg), 65'(exp_bg(n, exp_thr)));
    chk(underflow == exp_u, "R7 underflow", 65'(underflow), 65'(exp_u));
    chk(overflow == exp_o, "R6 overflow", 65'(overflow), 65'(exp_o));
  endtask

  task automatic cyc(input logic we, input logic [63:0] wd, input logic wc, input logic re,
                     input logic tw, input logic [5:0] td, input logic [1:0] clr);
    int pre;
    logic su, so;
    wr_en = we; wr_word = wd; wr_cursor = wc; rd_en = re;
    thr_we = tw; thr_wdata = td; flag_clr = clr;
    pre = mq.size();
    su = re && pre == 0;
    so = we && pre == 64;
    @(posedge clk);
    #1;
    if (re && pre > 0) exp_rd = mq.pop_front();
    if (we && pre < 64) mq.push_back({wc, wd});
    exp_u = su || (exp_u && !clr[0]);
    exp_o = so || (exp_o && !clr[1]);
    if (tw) exp_thr = int'(td);
    wr_en = 1'b0; rd_en = 1'b0; thr_we = 1'b0; flag_clr = '0;
    check_all();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed = 32'h1d5a;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1: values while reset is held
    chk(level == 0 && !underflow && !overflow && rd_word == 0 && !rd_cursor, "R1 reset state",
        {underflow, overflow, level, rd_word[55:0]}, '0);
    chk(req_urgent && !req_bg, "R1 reset requests", 65'({req_urgent, req_bg}), 65'b10);
    rst_n = 1'b1;
    #1;
    check_all();

    // R2: a full burst streamed back to back up to 64 entries
    for (int i = 0; i < 64; i++)
      cyc(1'b1, {$urandom, $urandom}, 1'(i % 5 == 0), 1'b0, 1'b0, '0, '0);
    // R6: writes into a full queue are dropped
    cyc(1'b1, 64'hdead_beef_0000_0001, 1'b1, 1'b0, 1'b0, '0, '0);
    chk(overflow, "R6 overflow set", 65'(overflow), 65'd1);
    cyc(1'b1, 64'hdead_beef_0000_0002, 1'b0, 1'b1, 1'b0, '0, '0);
    // R4: watermark 0 disables urgent while draining
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b1, 6'd0, '0);
    while (mq.size() > 0) cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0);
    chk(!req_urgent, "R4 zero watermark at empty", 65'(req_urgent), 65'd0);
    // R7: read while empty holds the last word
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0);
    chk(underflow, "R7 underflow set", 65'(underflow), 65'd1);
    // R8: set and clear in one cycle keep the flag set, then both clear
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, 2'b01);
    chk(underflow, "R8 set beats clear", 65'(underflow), 65'd1);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 2'b11);
    chk(!underflow && !overflow, "R8 both cleared", 65'({underflow, overflow}), 65'd0);
    // R9: watermark takes effect right after the write edge
    for (int i = 0; i < 8; i++) cyc(1'b1, 64'(i), 1'b0, 1'b0, 1'b0, '0, '0);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 6'd9, '0);
    chk(req_urgent && !req_bg, "R9 watermark 9 at level 8", 65'({req_urgent, req_bg}), 65'b10);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 6'd8, '0);
    chk(!req_urgent && req_bg, "R9 watermark 8 at level 8", 65'({req_urgent, req_bg}), 65'b01);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 6'd63, '0);

    // random phases with changing read/write bias and watermark
    for (int ph = 0; ph < 12; ph++) begin
      int wp = 20 + int'($urandom % 70);
      int rp = 20 + int'($urandom % 70);
      for (int i = 0; i < 300; i++) begin
        logic tw = ($urandom % 40) == 0;
        cyc(int'($urandom % 100) < wp, {$urandom, $urandom}, 1'($urandom), int'($urandom % 100) < rp,
            tw, 6'($urandom), 2'(($urandom % 16 == 0) ? $urandom : 0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule